// File: doc/BRIEF.md
# Store Queue with In-Order Writeback

This block buffers the stores of an out-of-order core between dispatch and memory. A store takes the next slot at the tail in program order and carries its sequence number. When it executes, its address, byte size and data word are written into that slot. A commit request makes every store at or below a given sequence number committed and eligible for writeback. A writeback pointer then walks forward from the oldest store that has not been sent and offers up to one store per cache port each cycle on valid/ready request lanes.

A slot is freed only after memory acknowledges the write, not when the store commits. The head then advances by one slot per cycle over acknowledged entries. A squash removes the youngest stores whose sequence numbers lie above a given value by pulling the tail back. It never removes a committed store and never moves the writeback pointer. The ring keeps one slot unused, so it never holds more than `SLOTS-1` stores.

Top module: `store_queue`

## Requirements
- R1: `alloc_ready` is low when `occupancy` equals `SLOTS-1` (7 by default) or when `squash_valid` is high. An allocation offered while `alloc_ready` is low is ignored and leaves `occupancy` unchanged.
- R2: An accepted allocation takes slot `alloc_idx`. Slots are handed out in ring order starting at 0 after reset, and the store's committed, can-writeback and completed flags start clear, so an uncommitted store is never offered to memory.
- R3: An execute writes `exe_addr`, `exe_size` and `exe_data` into slot `exe_idx`. Those values appear unchanged on the request lane that later carries that store, and execution has no error path.
- R4: A commit with sequence number C marks every resident, not yet committed store with sequence number at most C (unsigned compare) as committed and eligible. `wb_pending` rises by the number of stores newly marked, in the next cycle.
- R5: Requests leave in queue order starting at the writeback pointer. Lane k carries the k-th store after the pointer, and lane k is valid only if that store is committed and not completed and lanes 0 to k-1 are valid and ready in the same cycle. At most `PORTS` stores are issued per cycle.
- R6: A lane that is valid but not ready leaves the writeback pointer unchanged, so the same slot is offered again in the next cycle.
- R7: An acknowledge on `mem_ack_idx` marks that slot completed. One cycle later, if that slot is the head, the head advances and `occupancy` falls by one. At most one slot is released per cycle, and a committed store that is not acknowledged is never released.
- R8: A squash with sequence number S removes every resident uncommitted store whose sequence number exceeds S, taking effect in the next cycle. Committed stores and the writeback pointer are not affected.
- R9: `head_seq` and `tail_seq` show the sequence numbers of the oldest and youngest resident stores, and both read 0 when the queue is empty.
- R10: `wb_pending` falls by the number of requests accepted in a cycle (valid and ready), so it always counts committed stores not yet accepted by memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated store |
| alloc_ready | output | 1 | Allocation can be accepted this cycle |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| exe_valid | input | 1 | Execute result for a store |
| exe_idx | input | IDX_W | Slot of the executed store |
| exe_addr | input | ADDR_W | Store address |
| exe_size | input | SIZE_W | Store size in bytes |
| exe_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest sequence number to commit |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores above this number are removed |
| mem_req_valid | output | PORTS | Per-lane write request valid |
| mem_req_ready | input | PORTS | Per-lane write request ready |
| mem_req_idx | output | PORTS x IDX_W | Slot carried by each lane, returned on acknowledge |
| mem_req_addr | output | PORTS x ADDR_W | Address per lane |
| mem_req_size | output | PORTS x SIZE_W | Byte size per lane |
| mem_req_data | output | PORTS x DATA_W | Data per lane |
| mem_ack_valid | input | 1 | Write completion |
| mem_ack_idx | input | IDX_W | Slot whose write completed |
| occupancy | output | CNT_W | Number of resident stores |
| wb_pending | output | CNT_W | Committed stores not yet accepted by memory |
| head_seq | output | SEQ_W | Sequence number of the oldest store, 0 if empty |
| tail_seq | output | SEQ_W | Sequence number of the youngest store, 0 if empty |

## Verification
Allocation, execute, commit, squash and acknowledge all act at a rising edge, so their effects on `occupancy`, `wb_pending`, the sequence outputs and lane eligibility are due one cycle later. A release is due one further cycle after its acknowledge. The request lanes are combinational from the stored state and `mem_req_ready`, so they are due in the same cycle as the ready they depend on. The bench drives inputs on the falling edge and compares every output against a behavioural queue model shortly after. It advances the model at the rising edge from the values that were presented, which keeps each check on the cycle its result is due.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Reduce any integer into [0, n) for ring index arithmetic.
  function automatic int ring_wrap(input int v, input int n);
    int r;
    r = v % n;
    if (r < 0) r = r + n;
    return r;
  endfunction

endpackage

// File: rtl/sq_slot.sv
module sq_slot #(
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic              exe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  input  logic              ack_i,
  output logic [SEQ_W-1:0]  seq_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [DATA_W-1:0] data_o,
  output logic              cmt_o,
  output logic              cwb_o,
  output logic              cpl_o
);

  logic cmt_q, cmt_d;
  logic cwb_q, cwb_d;
  logic cpl_q, cpl_d;
  logic [SEQ_W-1:0]  seq_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] data_q;

  // Flag next state: allocation clears, commit and ack set.
  always_comb begin
    cmt_d = cmt_q;
    cwb_d = cwb_q;
    cpl_d = cpl_q;
    if (alloc_i) begin
      cmt_d = 1'b0;
      cwb_d = 1'b0;
      cpl_d = 1'b0;
    end else begin
      if (commit_i) begin
        cmt_d = 1'b1;
        cwb_d = 1'b1;
      end
      if (ack_i) cpl_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmt_q <= 1'b0;
      cwb_q <= 1'b0;
      cpl_q <= 1'b0;
    end else begin
      cmt_q <= cmt_d;
      cwb_q <= cwb_d;
      cpl_q <= cpl_d;
    end
  end

  // Payload registers: enable-only, no reset needed.
  always_ff @(posedge clk) begin
    if (alloc_i) seq_q <= seq_i;
    if (exe_i) begin
      addr_q <= addr_i;
      size_q <= size_i;
      data_q <= data_i;
    end
  end

  assign seq_o  = seq_q;
  assign addr_o = addr_q;
  assign size_o = size_q;
  assign data_o = data_q;
  assign cmt_o  = cmt_q;
  assign cwb_o  = cwb_q;
  assign cpl_o  = cpl_q;

endmodule

// File: rtl/sq_wb_issue.sv
module sq_wb_issue #(
  parameter int SLOTS = 8,
  parameter int PORTS = 2,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int LANE_W = $clog2(PORTS + 1)
) (
  input  logic [IDX_W-1:0]            wb_ptr,
  input  logic [CNT_W-1:0]            span,
  input  logic [SLOTS-1:0]            cwb,
  input  logic [SLOTS-1:0]            cpl,
  input  logic [PORTS-1:0]            ready,
  output logic [PORTS-1:0]            valid,
  output logic [PORTS-1:0][IDX_W-1:0] idx,
  output logic [LANE_W-1:0]           n_iss
);

  // gate[k] high when every lane below k was valid and accepted.
  logic [PORTS:0] gate;
  assign gate[0] = 1'b1;

  for (genvar k = 0; k < PORTS; k++) begin : g_lane
    assign idx[k]     = IDX_W'(sq_pkg::ring_wrap(int'(wb_ptr) + k, SLOTS));
    assign valid[k]   = gate[k] && (k < int'(span)) && cwb[idx[k]] && !cpl[idx[k]];
    assign gate[k+1]  = valid[k] && ready[k];
  end

  // Ports used this cycle: recomputed every cycle, capped by PORTS lanes.
  assign n_iss = LANE_W'($countones(valid & ready));

endmodule

// File: rtl/store_queue.sv
module store_queue #(
  parameter int SLOTS  = 8,
  parameter int PORTS  = 2,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int LANE_W = $clog2(PORTS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_valid,
  input  logic [SEQ_W-1:0]             alloc_seq,
  output logic                         alloc_ready,
  output logic [IDX_W-1:0]             alloc_idx,
  input  logic                         exe_valid,
  input  logic [IDX_W-1:0]             exe_idx,
  input  logic [ADDR_W-1:0]            exe_addr,
  input  logic [SIZE_W-1:0]            exe_size,
  input  logic [DATA_W-1:0]            exe_data,
  input  logic                         commit_valid,
  input  logic [SEQ_W-1:0]             commit_seq,
  input  logic                         squash_valid,
  input  logic [SEQ_W-1:0]             squash_seq,
  output logic [PORTS-1:0]             mem_req_valid,
  input  logic [PORTS-1:0]             mem_req_ready,
  output logic [PORTS-1:0][IDX_W-1:0]  mem_req_idx,
  output logic [PORTS-1:0][ADDR_W-1:0] mem_req_addr,
  output logic [PORTS-1:0][SIZE_W-1:0] mem_req_size,
  output logic [PORTS-1:0][DATA_W-1:0] mem_req_data,
  input  logic                         mem_ack_valid,
  input  logic [IDX_W-1:0]             mem_ack_idx,
  output logic [CNT_W-1:0]             occupancy,
  output logic [CNT_W-1:0]             wb_pending,
  output logic [SEQ_W-1:0]             head_seq,
  output logic [SEQ_W-1:0]             tail_seq
);

  localparam int MAX_OCC = SLOTS - 1;

  // Ring state
  logic [IDX_W-1:0] head_q, head_d;
  logic [IDX_W-1:0] tail_q, tail_d;
  logic [IDX_W-1:0] wb_q,   wb_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic [CNT_W-1:0] pend_q, pend_d;

  // Per-slot views
  logic [SEQ_W-1:0]  s_seq  [SLOTS];
  logic [ADDR_W-1:0] s_addr [SLOTS];
  logic [SIZE_W-1:0] s_size [SLOTS];
  logic [DATA_W-1:0] s_data [SLOTS];
  logic [SLOTS-1:0]  s_cmt, s_cwb, s_cpl;
  logic [SLOTS-1:0]  occ, commit_hit, keep, alloc_here, exe_here, ack_here;

  logic             alloc_fire;
  logic             pop;
  logic [CNT_W-1:0] kept;
  logic [CNT_W-1:0] n_commit;
  logic [CNT_W-1:0] cmt_kept;
  logic [CNT_W-1:0] wb_span;
  logic [LANE_W-1:0] n_iss;
  logic [IDX_W-1:0] last_idx;

  // ---------------------------------------------------------------
  // Slot array
  // ---------------------------------------------------------------
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign occ[i] = sq_pkg::ring_wrap(i - int'(head_q), SLOTS) < int'(cnt_q);
    assign alloc_here[i] = alloc_fire && (tail_q == IDX_W'(i));
    assign exe_here[i]   = exe_valid && (exe_idx == IDX_W'(i));
    assign ack_here[i]   = mem_ack_valid && (mem_ack_idx == IDX_W'(i));
    assign commit_hit[i] = commit_valid && occ[i] && !s_cmt[i] && (s_seq[i] <= commit_seq);
    assign keep[i]       = occ[i] && (s_cmt[i] || (s_seq[i] <= squash_seq));

    sq_slot #(
      .SEQ_W (SEQ_W),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .SIZE_W(SIZE_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc_i (alloc_here[i]),
      .seq_i   (alloc_seq),
      .exe_i   (exe_here[i]),
      .addr_i  (exe_addr),
      .size_i  (exe_size),
      .data_i  (exe_data),
      .commit_i(commit_hit[i]),
      .ack_i   (ack_here[i]),
      .seq_o   (s_seq[i]),
      .addr_o  (s_addr[i]),
      .size_o  (s_size[i]),
      .data_o  (s_data[i]),
      .cmt_o   (s_cmt[i]),
      .cwb_o   (s_cwb[i]),
      .cpl_o   (s_cpl[i])
    );
  end

  // ---------------------------------------------------------------
  // Writeback lanes
  // ---------------------------------------------------------------
  assign wb_span = CNT_W'(sq_pkg::ring_wrap(int'(tail_q) - int'(wb_q), SLOTS));

  sq_wb_issue #(
    .SLOTS(SLOTS),
    .PORTS(PORTS)
  ) u_issue (
    .wb_ptr(wb_q),
    .span  (wb_span),
    .cwb   (s_cwb),
    .cpl   (s_cpl),
    .ready (mem_req_ready),
    .valid (mem_req_valid),
    .idx   (mem_req_idx),
    .n_iss (n_iss)
  );

  for (genvar k = 0; k < PORTS; k++) begin : g_lane_data
    assign mem_req_addr[k] = s_addr[mem_req_idx[k]];
    assign mem_req_size[k] = s_size[mem_req_idx[k]];
    assign mem_req_data[k] = s_data[mem_req_idx[k]];
  end

  // ---------------------------------------------------------------
  // Next state
  // ---------------------------------------------------------------
  assign alloc_ready = (int'(cnt_q) < MAX_OCC) && !squash_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_q;
  assign pop         = (cnt_q != '0) && s_cpl[head_q];
  assign kept        = CNT_W'($countones(keep));
  assign n_commit    = CNT_W'($countones(commit_hit));
  assign cmt_kept    = CNT_W'($countones(occ & s_cmt));

  always_comb begin
    head_d = pop ? IDX_W'(sq_pkg::ring_wrap(int'(head_q) + 1, SLOTS)) : head_q;
    wb_d   = IDX_W'(sq_pkg::ring_wrap(int'(wb_q) + int'(n_iss), SLOTS));
    pend_d = pend_q + n_commit - CNT_W'(n_iss);
    if (squash_valid) begin
      tail_d = IDX_W'(sq_pkg::ring_wrap(int'(head_q) + int'(kept), SLOTS));
      cnt_d  = kept - CNT_W'(pop);
    end else begin
      tail_d = alloc_fire ? IDX_W'(sq_pkg::ring_wrap(int'(tail_q) + 1, SLOTS)) : tail_q;
      cnt_d  = cnt_q + CNT_W'(alloc_fire) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      wb_q   <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      wb_q   <= wb_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  // ---------------------------------------------------------------
  // Status outputs
  // ---------------------------------------------------------------
  assign last_idx   = IDX_W'(sq_pkg::ring_wrap(int'(tail_q) - 1, SLOTS));
  assign occupancy  = cnt_q;
  assign wb_pending = pend_q;
  assign head_seq   = (cnt_q != '0) ? s_seq[head_q]   : '0;
  assign tail_seq   = (cnt_q != '0) ? s_seq[last_idx] : '0;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAX_OCC);

  p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_q) == MAX_OCC) |=> (cnt_q <= $past(cnt_q)));

  p_first_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && cnt_q == '0) |=> (head_seq == $past(alloc_seq)));

  p_pend_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(n_iss) <= pend_q);

  p_refuse_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid[0] && !mem_req_ready[0]) |=> (wb_q == $past(wb_q)));

  p_squash_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (cnt_q >= $past(cmt_kept) - CNT_W'($past(pop))));

  p_hold_unacked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !s_cpl[head_q] && !squash_valid) |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: tb/tb_store_queue.sv
module tb_store_queue;

  localparam int SLOTS  = 8;
  localparam int PORTS  = 2;
  localparam int SEQ_W  = 16;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int SIZE_W = 4;
  localparam int IDX_W  = 3;
  localparam int CNT_W  = 4;

  logic clk, rst_n;
  logic alloc_valid, alloc_ready;
  logic [SEQ_W-1:0] alloc_seq;
  logic [IDX_W-1:0] alloc_idx;
  logic exe_valid;
  logic [IDX_W-1:0] exe_idx;
  logic [ADDR_W-1:0] exe_addr;
  logic [SIZE_W-1:0] exe_size;
  logic [DATA_W-1:0] exe_data;
  logic commit_valid, squash_valid;
  logic [SEQ_W-1:0] commit_seq, squash_seq;
  logic [PORTS-1:0] mem_req_valid, mem_req_ready;
  logic [PORTS-1:0][IDX_W-1:0]  mem_req_idx;
  logic [PORTS-1:0][ADDR_W-1:0] mem_req_addr;
  logic [PORTS-1:0][SIZE_W-1:0] mem_req_size;
  logic [PORTS-1:0][DATA_W-1:0] mem_req_data;
  logic mem_ack_valid;
  logic [IDX_W-1:0] mem_ack_idx;
  logic [CNT_W-1:0] occupancy, wb_pending;
  logic [SEQ_W-1:0] head_seq, tail_seq;

  store_queue #(
    .SLOTS(SLOTS), .PORTS(PORTS), .SEQ_W(SEQ_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .exe_valid(exe_valid), .exe_idx(exe_idx), .exe_addr(exe_addr),
    .exe_size(exe_size), .exe_data(exe_data),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_idx(mem_req_idx), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_data(mem_req_data),
    .mem_ack_valid(mem_ack_valid), .mem_ack_idx(mem_ack_idx),
    .occupancy(occupancy), .wb_pending(wb_pending),
    .head_seq(head_seq), .tail_seq(tail_seq)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int seq;
    int slot;
    bit execd;
    bit cmt;
    bit issued;
    bit cpl;
  } ent_t;

  ent_t q[$];
  int   ackq[$];
  int   head_slot;
  int   pend;
  int   next_seq;
  int   checks;
  int   errors;
  bit   auto_exe;
  bit   ack_en;
  bit   ev [PORTS];
  int   wbpos;
  bit   ready_e;
  int   idx_e;

  function automatic logic [ADDR_W-1:0] addr_of(int s);
    return ADDR_W'(s * 8 + (s % 8));
  endfunction
  function automatic logic [SIZE_W-1:0] size_of(int s);
    return SIZE_W'((s % 8) + 1);
  endfunction
  function automatic logic [DATA_W-1:0] data_of(int s);
    return {16'(s), 16'hA5C3 ^ 16'(s), 32'(s * 977)};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // One clock: auto inputs, compare at settle, advance model at rising edge.
  task automatic step();
    int found;
    int seq_of_slot;
    bit pop_flag;
    int n;
    alloc_seq = SEQ_W'(next_seq);
    mem_ack_valid = ack_en && (ackq.size() > 0);
    mem_ack_idx   = mem_ack_valid ? IDX_W'(ackq[0]) : '0;
    found = -1;
    foreach (q[i]) if (found < 0 && !q[i].execd) found = i;
    exe_valid = auto_exe && (found >= 0);
    if (exe_valid) begin
      exe_idx  = IDX_W'(q[found].slot);
      exe_addr = addr_of(q[found].seq);
      exe_size = size_of(q[found].seq);
      exe_data = data_of(q[found].seq);
    end else begin
      exe_idx = '0; exe_addr = '0; exe_size = '0; exe_data = '0;
    end
    #1;
    // expectations
    ready_e = (q.size() < SLOTS - 1) && !squash_valid;
    idx_e   = (head_slot + q.size()) % SLOTS;
    wbpos   = q.size();
    for (int i = q.size() - 1; i >= 0; i--) if (!q[i].issued) wbpos = i;
    begin
      bit gate;
      gate = 1'b1;
      for (int k = 0; k < PORTS; k++) begin
        int p;
        p = wbpos + k;
        ev[k] = gate && (p < q.size()) && q[p].cmt && !q[p].cpl;
        gate  = ev[k] && mem_req_ready[k];
      end
    end
    chk(alloc_ready === ready_e, "R1 alloc_ready", alloc_ready, ready_e);
    chk(alloc_idx === IDX_W'(idx_e), "R2 alloc_idx", alloc_idx, idx_e);
    chk(occupancy === CNT_W'(q.size()), "R7/R8 occupancy", occupancy, q.size());
    chk(wb_pending === CNT_W'(pend), "R4/R10 wb_pending", wb_pending, pend);
    chk(head_seq === SEQ_W'(q.size() ? q[0].seq : 0), "R9 head_seq", head_seq, q.size() ? q[0].seq : 0);
    chk(tail_seq === SEQ_W'(q.size() ? q[q.size()-1].seq : 0), "R9 tail_seq", tail_seq,
        q.size() ? q[q.size()-1].seq : 0);
    for (int k = 0; k < PORTS; k++) begin
      chk(mem_req_valid[k] === ev[k], "R5/R6 lane valid", mem_req_valid[k], ev[k]);
      if (ev[k]) begin
        seq_of_slot = q[wbpos + k].seq;
        chk(mem_req_idx[k] === IDX_W'(q[wbpos + k].slot), "R5 lane idx", mem_req_idx[k], q[wbpos + k].slot);
        chk(mem_req_addr[k] === addr_of(seq_of_slot), "R3 lane addr", mem_req_addr[k], addr_of(seq_of_slot));
        chk(mem_req_size[k] === size_of(seq_of_slot), "R3 lane size", mem_req_size[k], size_of(seq_of_slot));
        chk(mem_req_data[k] === data_of(seq_of_slot), "R3 lane data", mem_req_data[k], data_of(seq_of_slot));
      end
    end
    @(posedge clk);
    // model update from the presented values
    pop_flag = (q.size() > 0) && q[0].cpl;
    n = 0;
    for (int k = 0; k < PORTS; k++) begin
      if (ev[k] && mem_req_ready[k]) begin
        q[wbpos + k].issued = 1'b1;
        ackq.push_back(q[wbpos + k].slot);
        n++;
      end
    end
    pend -= n;
    if (mem_ack_valid) begin
      foreach (q[i]) if (q[i].slot == int'(mem_ack_idx)) q[i].cpl = 1'b1;
      void'(ackq.pop_front());
    end
    if (exe_valid) q[found].execd = 1'b1;
    if (commit_valid) begin
      foreach (q[i]) if (!q[i].cmt && q[i].seq <= int'(commit_seq)) begin
        q[i].cmt = 1'b1;
        pend++;
      end
    end
    if (squash_valid) begin
      while (q.size() > 0 && !q[q.size()-1].cmt && q[q.size()-1].seq > int'(squash_seq))
        void'(q.pop_back());
    end
    if (alloc_valid && ready_e) begin
      ent_t e;
      e.seq = next_seq; e.slot = idx_e;
      e.execd = 1'b0; e.cmt = 1'b0; e.issued = 1'b0; e.cpl = 1'b0;
      q.push_back(e);
      next_seq++;
    end
    if (pop_flag) begin
      void'(q.pop_front());
      head_slot = (head_slot + 1) % SLOTS;
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    alloc_valid = 1'b0; commit_valid = 1'b0; squash_valid = 1'b0;
    commit_seq = '0; squash_seq = '0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [IDX_W-1:0] held_idx;
    checks = 0; errors = 0; head_slot = 0; pend = 0; next_seq = 1;
    auto_exe = 1'b1; ack_en = 1'b0;
    rst_n = 1'b0;
    idle_inputs();
    mem_req_ready = '0; mem_ack_valid = 1'b0; mem_ack_idx = '0;
    exe_valid = 1'b0; exe_idx = '0; exe_addr = '0; exe_size = '0; exe_data = '0;
    alloc_seq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state (R1, R9)
    step();
    chk(occupancy == 0 && head_seq == 0 && tail_seq == 0, "R9 reset empty", occupancy, 0);

    // Three stores, commit the first two (R2, R3, R4)
    alloc_valid = 1'b1;
    repeat (3) step();
    alloc_valid = 1'b0;
    repeat (2) step();
    commit_valid = 1'b1; commit_seq = 16'd2;
    step();
    idle_inputs();
    step();
    chk(wb_pending == 2, "R4 pending after commit", wb_pending, 2);
    // Refused lane keeps the same slot (R6)
    held_idx = mem_req_idx[0];
    step();
    chk(mem_req_valid[0] && mem_req_idx[0] == held_idx, "R6 retry same slot", mem_req_idx[0], held_idx);
    mem_req_ready = 2'b11;
    step();
    mem_req_ready = 2'b00;
    ack_en = 1'b1;
    repeat (4) step();
    chk(occupancy == 1, "R7 released only acked", occupancy, 1);

    // Fill to the limit (R1)
    alloc_valid = 1'b1;
    repeat (9) step();
    alloc_valid = 1'b0;
    repeat (2) step();
    chk(occupancy == SLOTS - 1 && !alloc_ready, "R1 full", occupancy, SLOTS - 1);

    // Squash spares committed stores (R8)
    commit_valid = 1'b1; commit_seq = 16'd5;
    step();
    idle_inputs();
    squash_valid = 1'b1; squash_seq = 16'd4;
    step();
    idle_inputs();
    step();
    chk(occupancy == 3 && tail_seq == 5, "R8 committed kept", occupancy, 3);

    mem_req_ready = 2'b11;
    repeat (10) step();
    chk(occupancy == 0 && wb_pending == 0, "R10 drained", wb_pending, 0);

    // Mixed traffic
    for (int it = 0; it < 3000; it++) begin
      int last_exec;
      idle_inputs();
      last_exec = -1;
      foreach (q[i]) if (q[i].execd) last_exec = q[i].seq;
      alloc_valid = ($urandom % 2) == 1;
      if (last_exec >= 0 && ($urandom % 3) == 0) begin
        commit_valid = 1'b1; commit_seq = SEQ_W'(last_exec);
      end else if (q.size() > 0 && ($urandom % 20) == 0) begin
        squash_valid = 1'b1;
        squash_seq = SEQ_W'(q[$urandom % q.size()].seq - int'($urandom % 2));
      end
      mem_req_ready = PORTS'($urandom);
      ack_en = ($urandom % 2) == 1;
      step();
    end

    // Drain everything
    idle_inputs();
    mem_req_ready = 2'b11; ack_en = 1'b1;
    for (int it = 0; it < 60; it++) begin
      commit_valid = 1'b1; commit_seq = SEQ_W'(next_seq);
      step();
    end
    idle_inputs();
    step();
    chk(occupancy == 0, "R7 final empty", occupancy, 0);

    summary();
    $finish;
  end

endmodule